// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a memory-mapped MDIO master for indirect (Clause 45) register access to external PHYs. Software first places a 16-bit register address in the address register at offset 0x8. It then writes the command register at offset 0x0 with a port address, a device address, a 3-bit opcode and, for a write, the data word. That second write starts the access. The block sends an address frame and then a write or read frame on MDC/MDIO, with no further software action between the two.

While the access runs, software polls a busy flag in the command register. When busy drops after a read, a read-valid flag is set and the captured word is in the data field. The register interface has a single-cycle write strobe and a combinational read port. The MDIO pad is split into an output value, an output enable and an input.

The sequencer has three states:
- `ST_IDLE`: MDC is held low.
- `ST_ADDR_FRM`: the address frame is sent.
- `ST_DATA_FRM`: the write or read frame is sent.

It has three transitions:
- `T_START` (`ST_IDLE` to `ST_ADDR_FRM`): an accepted command write.
- `T_ADDR_DONE` (`ST_ADDR_FRM` to `ST_DATA_FRM`): the high half of bit 63 of the address frame ends.
- `T_DATA_DONE` (`ST_DATA_FRM` to `ST_IDLE`): the high half of bit 63 of the second frame ends. Busy is cleared on this transition, and for a read the data field and read-valid are loaded.

Top module: `c45_mdio_master`

## Requirements
- R1: After reset both registers read zero, MDC is low and the MDIO output enable is low.
- R2: Offset 0x8 holds the 16-bit register address and reads back as {16'b0, address}; upper write bits are dropped. Offsets other than 0x0 and 0x8 read zero and writes to them have no effect.
- R3: A write to offset 0x0 with opcode 101 (write) or 111 (read) while idle starts an access. Bit 30 (busy) reads 1 from the next cycle until the access has finished, which is 256*MDC_HALF clock cycles after the write.
- R4: The command register fields are: bits 15:0 data, bits 20:16 port address, bits 25:21 device address, bits 28:26 opcode, bit 29 read-valid, bit 30 busy, bit 31 reads 0.
- R5: The address frame, MSB first on MDIO, is 32 ones, then 00, 00, port (5 bits), device (5 bits), 10, and the 16-bit register address.
- R6: For opcode 101 the second frame is 32 ones, then 00, 01, port, device, 10, and the data field, all driven by the block.
- R7: For opcode 111 the second frame drives 32 ones, 00, 11, port and device. The output enable is then low for the last 18 bit times (turnaround and data). The 16 bits sampled at the last 16 MDC rising edges are stored MSB first in bits 15:0, and bit 29 is set.
- R8: MDC is low while idle. Each bit is MDC_HALF cycles with MDC low, then MDC_HALF cycles with MDC high. MDIO and its enable change only while MDC is low, and one access gives exactly 128 MDC rising edges.
- R9: While busy, writes to offset 0x0 and 0x8 are ignored.
- R10: Read-valid is cleared when any access starts, and it stays 0 after a write access.
- R11: A write to offset 0x0 whose opcode is neither 101 nor 111 is ignored: no field changes and no access starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | AW | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | AW | Register read byte offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest situation to reach is a register write that lands in the middle of an access. It must leave both registers and the frame sequence untouched. The bench starts a read and waits until MDC pulses are under way. It then writes new values to both offsets, and after completion checks the readback and that exactly 128 rising edges occurred. A PHY model in the bench drives the turnaround zero and the read word from a count of MDC rising edges, so the captured frame can be compared bit for bit with the expected frame.

// File: rtl/c45_mdio_pkg.sv
package c45_mdio_pkg;

    localparam int DATA_W  = 16;
    localparam int PORT_W  = 5;
    localparam int DEV_W   = 5;
    localparam int OP_W    = 3;
    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int IDX_W   = $clog2(FRAME_BITS);
    localparam int RD_REL_IDX = PRE_BITS + 14;   // first bit time of turnaround
    localparam int RD_DAT_IDX = PRE_BITS + 16;   // first bit time of data

    localparam logic [OP_W-1:0] OP_WRITE = 3'b101;
    localparam logic [OP_W-1:0] OP_READ  = 3'b111;

    localparam int OFS_CMD  = 0;
    localparam int OFS_ADDR = 8;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ADDR_FRM = 2'd1,
        ST_DATA_FRM = 2'd2
    } seq_state_e;

endpackage

// File: rtl/c45_mdc_timer.sv
module c45_mdc_timer #(
    parameter int MDC_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(MDC_HALF - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/c45_mgmt_regs.sv
module c45_mgmt_regs
    import c45_mdio_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [31:0]         wr_data,
    input  logic [AW-1:0]       rd_addr,
    output logic [31:0]         rd_data,
    input  logic                seq_done,
    input  logic [DATA_W-1:0]   seq_rdata,
    output logic                start,
    output logic                is_read,
    output logic [PORT_W-1:0]   port,
    output logic [DEV_W-1:0]    dev,
    output logic [DATA_W-1:0]   reg_addr,
    output logic [DATA_W-1:0]   wr_word,
    output logic                busy,
    output logic                rvalid
);
    localparam logic [AW-1:0] A_CMD  = AW'(OFS_CMD);
    localparam logic [AW-1:0] A_ADDR = AW'(OFS_ADDR);

    logic [OP_W-1:0]   op_q;
    logic [PORT_W-1:0] port_q;
    logic [DEV_W-1:0]  dev_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] addr_q;
    logic              busy_q;
    logic              rvalid_q;
    logic              op_ok;
    logic              addr_wr;

    assign op_ok   = (wr_data[28:26] == OP_WRITE) || (wr_data[28:26] == OP_READ);
    assign start   = wr_en && !busy_q && (wr_addr == A_CMD) && op_ok;
    assign addr_wr = wr_en && !busy_q && (wr_addr == A_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            port_q   <= '0;
            dev_q    <= '0;
            data_q   <= '0;
            busy_q   <= 1'b0;
            rvalid_q <= 1'b0;
        end else if (start) begin
            op_q     <= wr_data[28:26];
            dev_q    <= wr_data[25:21];
            port_q   <= wr_data[20:16];
            data_q   <= wr_data[15:0];
            busy_q   <= 1'b1;
            rvalid_q <= 1'b0;
        end else if (seq_done) begin
            busy_q <= 1'b0;
            if (op_q == OP_READ) begin
                data_q   <= seq_rdata;
                rvalid_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (addr_wr) begin
            addr_q <= wr_data[15:0];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CMD) begin
            rd_data = {1'b0, busy_q, rvalid_q, op_q, dev_q, port_q, data_q};
        end else if (rd_addr == A_ADDR) begin
            rd_data = {16'b0, addr_q};
        end
    end

    assign is_read  = (op_q == OP_READ);
    assign port     = port_q;
    assign dev      = dev_q;
    assign reg_addr = addr_q;
    assign wr_word  = data_q;
    assign busy     = busy_q;
    assign rvalid   = rvalid_q;
endmodule

// File: rtl/c45_frame_seq.sv
module c45_frame_seq
    import c45_mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic              is_read,
    input  logic [PORT_W-1:0] port,
    input  logic [DEV_W-1:0]  dev,
    input  logic [DATA_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              mdio_i,
    output logic              run,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);
    seq_state_e        state_q, state_n;
    logic [IDX_W-1:0]  idx_q;
    logic              phase_q;
    logic [DATA_W-1:0] cap_q;
    logic              last_bit_end;
    logic              in_release;
    logic [31:0]       addr_frame;
    logic [31:0]       data_frame;
    logic [31:0]       cur_frame;

    assign last_bit_end = tick && phase_q && (idx_q == IDX_W'(FRAME_BITS - 1));
    assign in_release   = (state_q == ST_DATA_FRM) && is_read &&
                          (idx_q >= IDX_W'(RD_REL_IDX));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:     if (start)        state_n = ST_ADDR_FRM;  // T_START
            ST_ADDR_FRM: if (last_bit_end) state_n = ST_DATA_FRM;  // T_ADDR_DONE
            ST_DATA_FRM: if (last_bit_end) state_n = ST_IDLE;      // T_DATA_DONE
            default:                       state_n = ST_IDLE;
        endcase
    end

    // bit position, clock phase and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            phase_q <= 1'b0;
            cap_q   <= '0;
        end else if (start) begin
            idx_q   <= '0;
            phase_q <= 1'b0;
        end else if (tick) begin
            if (phase_q) begin
                phase_q <= 1'b0;
                idx_q   <= idx_q + 1'b1;
            end else begin
                phase_q <= 1'b1;
                if ((state_q == ST_DATA_FRM) && is_read &&
                    (idx_q >= IDX_W'(RD_DAT_IDX))) begin
                    cap_q <= {cap_q[DATA_W-2:0], mdio_i};
                end
            end
        end
    end

    assign addr_frame = {2'b00, 2'b00, port, dev, 2'b10, reg_addr};
    assign data_frame = {2'b00, (is_read ? 2'b11 : 2'b01), port, dev, 2'b10, wr_word};

    // outputs
    always_comb begin
        run       = 1'b0;
        done      = 1'b0;
        mdc       = 1'b0;
        mdio_oe   = 1'b0;
        mdio_o    = 1'b1;
        cur_frame = addr_frame;
        unique case (state_q)
            ST_IDLE: begin
                run = 1'b0;
            end
            ST_ADDR_FRM: begin
                run       = 1'b1;
                mdc       = phase_q;
                mdio_oe   = 1'b1;
                cur_frame = addr_frame;
            end
            ST_DATA_FRM: begin
                run       = 1'b1;
                mdc       = phase_q;
                mdio_oe   = !in_release;
                cur_frame = data_frame;
                done      = last_bit_end;
            end
            default: begin
                run = 1'b0;
            end
        endcase
        if (run && idx_q >= IDX_W'(PRE_BITS)) begin
            mdio_o = cur_frame[~idx_q[4:0]];
        end
    end

    assign rdata = cap_q;
endmodule

// File: rtl/c45_mdio_master.sv
module c45_mdio_master
    import c45_mdio_pkg::*;
#(
    parameter int MDC_HALF = 4,
    parameter int AW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [AW-1:0] reg_wr_addr,
    input  logic [31:0]   reg_wr_data,
    input  logic [AW-1:0] reg_rd_addr,
    output logic [31:0]   reg_rd_data,
    output logic          mdc,
    output logic          mdio_o,
    output logic          mdio_oe,
    input  logic          mdio_i
);
    logic              start;
    logic              is_read;
    logic [PORT_W-1:0] port;
    logic [DEV_W-1:0]  dev;
    logic [DATA_W-1:0] reg_addr_w;
    logic [DATA_W-1:0] wr_word;
    logic              busy_w;
    logic              rvalid_w;
    logic              run;
    logic              tick;
    logic              seq_done;
    logic [DATA_W-1:0] seq_rdata;

    c45_mgmt_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_addr   (reg_wr_addr),
        .wr_data   (reg_wr_data),
        .rd_addr   (reg_rd_addr),
        .rd_data   (reg_rd_data),
        .seq_done  (seq_done),
        .seq_rdata (seq_rdata),
        .start     (start),
        .is_read   (is_read),
        .port      (port),
        .dev       (dev),
        .reg_addr  (reg_addr_w),
        .wr_word   (wr_word),
        .busy      (busy_w),
        .rvalid    (rvalid_w)
    );

    c45_mdc_timer #(.MDC_HALF(MDC_HALF)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    c45_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tick     (tick),
        .is_read  (is_read),
        .port     (port),
        .dev      (dev),
        .reg_addr (reg_addr_w),
        .wr_word  (wr_word),
        .mdio_i   (mdio_i),
        .run      (run),
        .done     (seq_done),
        .rdata    (seq_rdata),
        .mdc      (mdc),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );
endmodule

// File: rtl/c45_mdio_checker.sv
module c45_mdio_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        rvalid,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        wr_en,
    input logic [15:0] addr_q
);
    // R8: clock stays low while no access runs
    p_mdc_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R8: data and enable hold through the MDC high half
    p_mdio_stable_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R7: pad is only driven during an access
    p_oe_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);

    // R10: read-valid never coexists with busy
    p_rvalid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !busy);

    // R10: a fresh access starts with read-valid low
    p_start_clears_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !rvalid);

    // R9: address register holds during an access
    p_addr_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> $stable(addr_q));
endmodule

bind c45_mdio_master c45_mdio_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_w),
    .rvalid  (rvalid_w),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .wr_en   (reg_wr_en),
    .addr_q  (reg_addr_w)
);

// File: tb/c45_mdio_master_tb.sv
module c45_mdio_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;
    localparam int AW = 4;
    localparam int NVEC = 4;

    // {is_read, port, dev, reg address, data (write word or PHY read word)}
    localparam logic [42:0] VEC [NVEC] = '{
        {1'b0, 5'h03, 5'h01, 16'h0000, 16'hA5C3},
        {1'b1, 5'h1F, 5'h1E, 16'hFFFF, 16'h8001},
        {1'b0, 5'h10, 5'h07, 16'h1234, 16'hFFFF},
        {1'b1, 5'h00, 5'h03, 16'h8000, 16'h0000}
    };

    logic          clk = 0;
    logic          rst_n = 0;
    logic          wr_en = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic          mdc, mdio_o, mdio_oe, mdio_i;

    int tests = 0;
    int fails = 0;

    int          edges = 0;
    int          base = 0;
    int          rel;
    logic [15:0] phy_word = '0;
    logic [127:0] cap_w = '0;
    logic [127:0] cap_oe = '0;
    logic        wire_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    c45_mdio_master #(.MDC_HALF(HALF), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
        .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: bit time = count of rising edges since access start
    assign rel = edges - base;
    always_comb begin
        mdio_i = 1'b1;
        if (rel == 64 + 47) mdio_i = 1'b0;
        else if (rel >= 112 && rel < 128) mdio_i = phy_word[127 - rel];
    end
    assign wire_v = mdio_oe ? mdio_o : mdio_i;

    always @(posedge mdc) begin
        if (rel >= 0 && rel < 128) begin
            cap_w[127 - rel]  <= wire_v;
            cap_oe[127 - rel] <= mdio_oe;
        end
        edges <= edges + 1;
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic reg_rd(input logic [AW-1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_idle(output int cyc);
        logic [31:0] v;
        cyc = 0;
        reg_rd(4'h0, v);
        while (v[30] && cyc < 5000) begin
            cyc++;
            @(negedge clk);
            reg_rd(4'h0, v);
        end
    endtask

    function automatic logic [31:0] cmd_word(input logic rd, input logic [4:0] p,
                                             input logic [4:0] d, input logic [15:0] w);
        return {3'b000, (rd ? 3'b111 : 3'b101), d, p, w};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] prev;
        int cyc;

        repeat (3) @(negedge clk);
        // R1: reset values
        reg_rd(4'h0, v); check("R1 cmd reset", 128'(v), 128'h0);
        reg_rd(4'h8, v); check("R1 addr reset", 128'(v), 128'h0);
        check("R1 mdc/oe reset", 128'({mdc, mdio_oe}), 128'h0);
        rst_n = 1;
        @(negedge clk);

        // R2: address register and unmapped offset
        reg_wr(4'h8, 32'hFFFF_ABCD);
        reg_rd(4'h8, v); check("R2 addr readback", 128'(v), 128'h0000_ABCD);
        reg_wr(4'h4, 32'h1234_5678);
        reg_rd(4'h4, v); check("R2 unmapped reads zero", 128'(v), 128'h0);
        reg_rd(4'h8, v); check("R2 unmapped write no effect", 128'(v), 128'h0000_ABCD);

        // table-driven accesses: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            logic        is_rd;
            logic [4:0]  p, d;
            logic [15:0] ra, w;
            logic [127:0] exp_w, exp_oe;
            {is_rd, p, d, ra, w} = VEC[i];
            phy_word = w;
            reg_wr(4'h8, {16'h0, ra});
            base = edges;
            reg_wr(4'h0, cmd_word(is_rd, p, d, is_rd ? 16'h0 : w));
            reg_rd(4'h0, v); check("R3 busy after start", 128'(v[30]), 128'h1);
            wait_idle(cyc);
            check("R3 access length", 128'(cyc), 128'(256 * HALF));
            check("R8 edge count", 128'(rel), 128'd128);
            exp_w = {32'hFFFF_FFFF, 2'b00, 2'b00, p, d, 2'b10, ra,
                     32'hFFFF_FFFF, 2'b00, (is_rd ? 2'b11 : 2'b01), p, d, 2'b10, w};
            exp_oe = is_rd ? {{110{1'b1}}, 18'b0} : {128{1'b1}};
            check(is_rd ? "R7 frames" : "R6 frames", cap_w, exp_w);
            check("R5 address frame", 128'(cap_w[127:64]), 128'(exp_w[127:64]));
            check("R7 output enable", cap_oe, exp_oe);
            reg_rd(4'h0, v);
            check("R4 cmd readback", 128'(v),
                  128'({1'b0, 1'b0, is_rd, (is_rd ? 3'b111 : 3'b101), d, p, w}));
        end

        // R11: bad opcode ignored
        reg_rd(4'h0, prev);
        reg_wr(4'h0, {3'b000, 3'b010, 5'h1, 5'h2, 16'h3333});
        reg_rd(4'h0, v); check("R11 bad opcode ignored", 128'(v), 128'(prev));
        repeat (3 * HALF) @(negedge clk);
        check("R11 no clock", 128'(mdc), 128'h0);

        // R9: writes during an access ignored
        phy_word = 16'h5A0F;
        reg_wr(4'h8, 32'h0000_0042);
        base = edges;
        reg_wr(4'h0, cmd_word(1'b1, 5'h09, 5'h04, 16'h0));
        repeat (40 * HALF) @(negedge clk);
        reg_wr(4'h8, 32'h0000_7777);
        reg_wr(4'h0, cmd_word(1'b0, 5'h11, 5'h11, 16'h9999));
        wait_idle(cyc);
        reg_rd(4'h8, v); check("R9 addr unchanged", 128'(v), 128'h42);
        reg_rd(4'h0, v);
        check("R9 cmd unchanged", 128'(v),
              128'({1'b0, 1'b0, 1'b1, 3'b111, 5'h04, 5'h09, 16'h5A0F}));
        check("R9 edge count", 128'(rel), 128'd128);

        // R10: read-valid cleared by a new access
        reg_wr(4'h0, cmd_word(1'b0, 5'h01, 5'h01, 16'h0001));
        reg_rd(4'h0, v); check("R10 rvalid cleared", 128'(v[30:29]), 128'h2);
        wait_idle(cyc);
        reg_rd(4'h0, v); check("R10 rvalid after write", 128'(v[30:29]), 128'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule